// File: doc/BRIEF.md
# Multi-Unit Pipeline Hazard Interlock

This block decides, for the instruction sitting in the register-read stage of a single-issue, five-stage, in-order pipeline, whether that instruction may move on into execution and where each of its operands should come from. The pipeline feeds two single-cycle integer units, one four-cycle floating-point unit and two two-cycle memory pipes, all fully pipelined. Instructions leave the register-read stage in program order. Once an instruction has entered a unit it never waits, so results can come back out of order.

Every execute and writeback stage of every unit is presented to the block as one producer slot carrying a valid bit and a destination register id. The same per-slot comparators serve both purposes. A source that matches a slot whose result already exists is steered to that slot's bypass path. A source that matches a slot still computing its result raises a stall. A destination that matches a long-latency stage which would finish after the new instruction raises a stall for the write-after-write hazard. When the stall is high, the surrounding pipeline holds its fetch, decode and register-read stages and puts a bubble into execute. The block is purely combinational from its data inputs. The clock and reset are used only by the embedded checks.

Top module: `hz_interlock`

## Requirements
- R1: When `in_vld` is low, `stall` is 0 and both forward selects are 0, whatever the slot contents.
- R2: A source whose youngest match is a slot that already holds a result drives its select to slot index + 1 and adds no stall. The slots that hold a result are integer E, integer W, FP E4, FP W, memory E2 and memory W.
- R3: A source whose youngest match is FP E1–E3 or memory E1 raises `stall`, and its select is 0.
- R4: Slot age (depth) is integer E=1, W=2; FP Ek=k, W=5; memory Ek=k, W=3. The match with the smallest depth wins. On equal depth the lower slot index wins. Older matches are ignored.
- R5: A destination that matches a valid FP E1–E3 or memory E1 slot raises `stall`. A destination match on any other slot never stalls.
- R6: Register id 0, a disabled source and a disabled destination never match.
- R7: A slot whose valid bit is low never matches.
- R8: Select code 0 means the register file. Code k (1..15) means slot k-1. The slot order is int0 E, int0 W, int1 E, int1 W, FP E1..E4, FP W, mem0 E1, E2, W, mem1 E1, E2, W. `slot_dst` packs slot s at bits [5s+4:5s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables checks |
| in_vld | input | 1 | Register-read stage holds a real instruction |
| src1_en | input | 1 | Source 1 is read |
| src1 | input | 5 | Source 1 register id |
| src2_en | input | 1 | Source 2 is read |
| src2 | input | 5 | Source 2 register id |
| dst_en | input | 1 | Instruction writes a register |
| dst | input | 5 | Destination register id |
| slot_vld | input | 15 | Valid bit per producer slot |
| slot_dst | input | 75 | Destination id per producer slot, packed |
| stall | output | 1 | Hold front stages, bubble into execute |
| fwd1_sel | output | 4 | Operand source for source 1 |
| fwd2_sel | output | 4 | Operand source for source 2 |

## Verification
Directed patterns place a single match on each class of slot. This separates forwarding from stalling and shows that write-after-write detection fires only on the long pipes. Conflict patterns put the same register in two slots at once, one ready and one not, in both age orders and with a depth tie, so that a wrong priority gives a different select or stall. Masking patterns use register 0, disabled fields, invalid slots and a bubble in the register-read stage, and expect no effect. Several thousand random slot states over a small register range add dense multi-way conflicts, each checked against a bench model built from the depth and readiness tables.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Latency of the unit that owns slot s (integer units are 1).
  function automatic int slot_lat(input int s, input int n_int,
                                  input int fp_lat, input int mem_lat);
    if (s < 2 * n_int) return 1;
    if (s < 2 * n_int + fp_lat + 1) return fp_lat;
    return mem_lat;
  endfunction

  // Stage number inside its unit: 1..lat for execute, lat+1 for writeback.
  // This is also the slot's depth (cycles since leaving register read).
  function automatic int slot_stage(input int s, input int n_int,
                                    input int fp_lat, input int mem_lat);
    if (s < 2 * n_int) return (s % 2) + 1;
    if (s < 2 * n_int + fp_lat + 1) return s - 2 * n_int + 1;
    return ((s - 2 * n_int - fp_lat - 1) % (mem_lat + 1)) + 1;
  endfunction

endpackage

// File: rtl/hz_slot_cmp.sv
module hz_slot_cmp #(
  parameter int REG_W = 5
) (
  input  logic             vld,
  input  logic [REG_W-1:0] tag,
  input  logic             a_en,
  input  logic [REG_W-1:0] a_id,
  input  logic             b_en,
  input  logic [REG_W-1:0] b_id,
  input  logic             w_en,
  input  logic [REG_W-1:0] w_id,
  output logic             a_hit,
  output logic             b_hit,
  output logic             w_hit
);
  logic tag_live;
  assign tag_live = vld && (tag != '0);
  assign a_hit = tag_live && a_en && (a_id == tag);
  assign b_hit = tag_live && b_en && (b_id == tag);
  assign w_hit = tag_live && w_en && (w_id == tag);
endmodule

// File: rtl/hz_src_pick.sv
module hz_src_pick
  import hz_pkg::*;
#(
  parameter int SLOTS   = 15,
  parameter int SEL_W   = 4,
  parameter int NUM_INT = 2,
  parameter int FP_LAT  = 4,
  parameter int MEM_LAT = 2
) (
  input  logic [SLOTS-1:0] hit,
  output logic [SEL_W-1:0] sel,
  output logic             blocked
);
  int  best;
  int  best_d;
  logic found;

  always_comb begin
    best   = 0;
    best_d = 0;
    found  = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (hit[s] && (!found ||
          slot_stage(s, NUM_INT, FP_LAT, MEM_LAT) < best_d)) begin
        found  = 1'b1;
        best   = s;
        best_d = slot_stage(s, NUM_INT, FP_LAT, MEM_LAT);
      end
    end
    blocked = found && (best_d < slot_lat(best, NUM_INT, FP_LAT, MEM_LAT));
    sel     = (found && !blocked) ? SEL_W'(best + 1) : '0;
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_INT = 2,
  parameter int FP_LAT  = 4,
  parameter int NUM_MEM = 2,
  parameter int MEM_LAT = 2,
  localparam int SLOTS  = NUM_INT * 2 + FP_LAT + 1 + NUM_MEM * (MEM_LAT + 1),
  localparam int SEL_W  = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic                   src1_en,
  input  logic [REG_W-1:0]       src1,
  input  logic                   src2_en,
  input  logic [REG_W-1:0]       src2,
  input  logic                   dst_en,
  input  logic [REG_W-1:0]       dst,
  input  logic [SLOTS-1:0]       slot_vld,
  input  logic [SLOTS*REG_W-1:0] slot_dst,
  output logic                   stall,
  output logic [SEL_W-1:0]       fwd1_sel,
  output logic [SEL_W-1:0]       fwd2_sel
);
  logic [SLOTS-1:0] hit1, hit2, hitw, waw_v, rdy_v;
  logic [REG_W-1:0] tag_a [SLOTS];
  logic             blk1, blk2;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam bool_lat = slot_lat(s, NUM_INT, FP_LAT, MEM_LAT);
    localparam bool_stg = slot_stage(s, NUM_INT, FP_LAT, MEM_LAT);
    assign tag_a[s] = slot_dst[s*REG_W +: REG_W];
    hz_slot_cmp #(.REG_W(REG_W)) u_cmp (
      .vld  (slot_vld[s]),
      .tag  (tag_a[s]),
      .a_en (in_vld && src1_en),
      .a_id (src1),
      .b_en (in_vld && src2_en),
      .b_id (src2),
      .w_en (in_vld && dst_en),
      .w_id (dst),
      .a_hit(hit1[s]),
      .b_hit(hit2[s]),
      .w_hit(hitw[s])
    );
    // Only a stage that finishes after a newly issued op can reorder writes.
    if (bool_stg < bool_lat) begin : g_waw
      assign waw_v[s] = hitw[s];
      assign rdy_v[s] = 1'b0;
    end else begin : g_nowaw
      assign waw_v[s] = 1'b0;
      assign rdy_v[s] = 1'b1;
    end
  end

  hz_src_pick #(.SLOTS(SLOTS), .SEL_W(SEL_W), .NUM_INT(NUM_INT),
                .FP_LAT(FP_LAT), .MEM_LAT(MEM_LAT)) u_pick1 (
    .hit(hit1), .sel(fwd1_sel), .blocked(blk1));
  hz_src_pick #(.SLOTS(SLOTS), .SEL_W(SEL_W), .NUM_INT(NUM_INT),
                .FP_LAT(FP_LAT), .MEM_LAT(MEM_LAT)) u_pick2 (
    .hit(hit2), .sel(fwd2_sel), .blocked(blk2));

  assign stall = blk1 || blk2 || (|waw_v);

  // ---------------- embedded checks ----------------
  logic [SEL_W-1:0] i1, i2;
  assign i1 = fwd1_sel - 1'b1;
  assign i2 = fwd2_sel - 1'b1;

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_vld |-> (!stall && fwd1_sel == '0 && fwd2_sel == '0));
  assert_fwd_rdy_R2: assert property (@(posedge clk) disable iff (rst)
    (fwd1_sel != '0) |-> rdy_v[i1]);
  assert_fwd_vld_R7: assert property (@(posedge clk) disable iff (rst)
    (fwd2_sel != '0) |-> slot_vld[i2]);
  assert_fwd_tag_R8: assert property (@(posedge clk) disable iff (rst)
    (fwd1_sel != '0) |-> (tag_a[i1] == src1));
  assert_zero_src1_R6: assert property (@(posedge clk) disable iff (rst)
    (!src1_en || src1 == '0) |-> (fwd1_sel == '0));
  assert_zero_src2_R6: assert property (@(posedge clk) disable iff (rst)
    (!src2_en || src2 == '0) |-> (fwd2_sel == '0));
endmodule

// File: tb/sim_hz_interlock.sv
module sim_hz_interlock;
  localparam int NS = 15;
  logic clk = 1'b0, rst = 1'b1;
  logic in_vld, s1_en, s2_en, d_en;
  logic [4:0] s1, s2, d;
  logic [NS-1:0] sv;
  logic [4:0] sd [NS];
  logic [NS*5-1:0] sd_flat;
  logic stall;
  logic [3:0] f1, f2;
  int total = 0, bad = 0;

  // Bench tables for the default configuration (R4, R2/R3, R5).
  int dep [NS] = '{1,2,1,2,1,2,3,4,5,1,2,3,1,2,3};
  bit rdy [NS] = '{1,1,1,1,0,0,0,1,1,0,1,1,0,1,1};
  bit waw [NS] = '{0,0,0,0,1,1,1,0,0,1,0,0,1,0,0};

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NS; i++) sd_flat[i*5 +: 5] = sd[i];

  hz_interlock u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .src1_en(s1_en), .src1(s1), .src2_en(s2_en), .src2(s2),
    .dst_en(d_en), .dst(d), .slot_vld(sv), .slot_dst(sd_flat),
    .stall(stall), .fwd1_sel(f1), .fwd2_sel(f2));

  // -1 = blocked, 0 = register file, k = slot k-1
  function automatic int pick(input logic en, input logic [4:0] r);
    int b = -1;
    if (!in_vld || !en || r == 0) return 0;
    for (int i = 0; i < NS; i++)
      if (sv[i] && sd[i] == r && (b < 0 || dep[i] < dep[b])) b = i;
    if (b < 0) return 0;
    return rdy[b] ? b + 1 : -1;
  endfunction

  function automatic logic ref_waw();
    if (!in_vld || !d_en || d == 0) return 1'b0;
    for (int i = 0; i < NS; i++)
      if (waw[i] && sv[i] && sd[i] == d) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clr();
    in_vld = 1'b1; s1_en = 1'b0; s2_en = 1'b0; d_en = 1'b0;
    s1 = '0; s2 = '0; d = '0; sv = '0;
    for (int i = 0; i < NS; i++) sd[i] = '0;
  endtask

  task automatic chk(input string tag, input logic est, input int e1, input int e2);
    #1;
    total++;
    if (stall !== est || f1 !== 4'(e1) || f2 !== 4'(e2)) begin
      bad++;
      $display("FAIL %s stall=%0d/%0d sel1=%0d/%0d sel2=%0d/%0d",
               tag, stall, est, f1, e1, f2, e2);
    end
  endtask

  task automatic chk_ref(input string tag);
    int p1, p2;
    p1 = pick(s1_en, s1);
    p2 = pick(s2_en, s2);
    chk(tag, (p1 < 0) || (p2 < 0) || ref_waw(),
        (p1 < 0) ? 0 : p1, (p2 < 0) ? 0 : p2);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clr(); in_vld = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); chk("R1 reset state", 1'b0, 0, 0);
    @(negedge clk); clr(); in_vld = 1'b0; s1_en = 1; s1 = 3; sv[4] = 1; sd[4] = 3;
    chk("R1 bubble ignored", 1'b0, 0, 0);
    @(negedge clk); clr(); s1_en = 1; s1 = 3; sv[0] = 1; sd[0] = 3;
    chk("R2 int E forward", 1'b0, 1, 0);
    @(negedge clk); clr(); s2_en = 1; s2 = 7; sv[14] = 1; sd[14] = 7;
    chk("R8 mem1 W code 15", 1'b0, 0, 15);
    @(negedge clk); clr(); s1_en = 1; s1 = 4; sv[5] = 1; sd[5] = 4;
    chk("R3 FP E2 stall", 1'b1, 0, 0);
    @(negedge clk); clr(); s1_en = 1; s1 = 6; sv[8] = 1; sd[8] = 6; sv[2] = 1; sd[2] = 6;
    chk("R4 youngest ready wins", 1'b0, 3, 0);
    @(negedge clk); clr(); s1_en = 1; s1 = 6; sv[4] = 1; sd[4] = 6; sv[1] = 1; sd[1] = 6;
    chk("R4 youngest not ready", 1'b1, 0, 0);
    @(negedge clk); clr(); s1_en = 1; s1 = 9; sv[9] = 1; sd[9] = 9; sv[2] = 1; sd[2] = 9;
    chk("R4 tie lower index", 1'b0, 3, 0);
    @(negedge clk); clr(); d_en = 1; d = 5; sv[6] = 1; sd[6] = 5;
    chk("R5 WAW FP E3", 1'b1, 0, 0);
    @(negedge clk); clr(); d_en = 1; d = 5; sv[12] = 1; sd[12] = 5;
    chk("R5 WAW mem E1", 1'b1, 0, 0);
    @(negedge clk); clr(); d_en = 1; d = 5;
    sv[0] = 1; sd[0] = 5; sv[7] = 1; sd[7] = 5; sv[10] = 1; sd[10] = 5; sv[14] = 1; sd[14] = 5;
    chk("R5 no WAW short stages", 1'b0, 0, 0);
    @(negedge clk); clr(); s1_en = 1; d_en = 1; sv[4] = 1; sv[0] = 1;
    chk("R6 register zero", 1'b0, 0, 0);
    @(negedge clk); clr(); s2 = 3; sv[5] = 1; sd[5] = 3; d = 3;
    chk("R6 disabled fields", 1'b0, 0, 0);
    @(negedge clk); clr(); s1_en = 1; s1 = 4; sd[5] = 4; d_en = 1; d = 4; sd[4] = 4;
    chk("R7 invalid slot", 1'b0, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_vld = ($urandom % 8) != 0;
      s1_en = $urandom % 2; s2_en = $urandom % 2; d_en = $urandom % 2;
      s1 = 5'($urandom % 6); s2 = 5'($urandom % 6); d = 5'($urandom % 6);
      for (int i = 0; i < NS; i++) begin
        sv[i] = ($urandom % 3) == 0;
        sd[i] = 5'($urandom % 6);
      end
      chk_ref("R2 R3 R4 R5 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule